// File: doc/BRIEF.md
# Predicated Vector Element Address Sequencer

This block expands one scalar-form load or store into a sequence of per-element effective addresses. At start it captures a vector length, a source predicate mask, a destination predicate mask, scalar/vector flags for the base, index, update and destination operands, an addressing form, an access width, an immediate and four register numbers. It then walks four element counters (source, destination, index, update). Each counter belongs to one operand and advances only when that operand is a vector. Before every element, each active counter steps past positions whose predicate bit is clear.

For each element the block reads the operand registers it needs through a request/response port. It then forms the address in one of five ways: unit stride, element stride, immediate-indexed, splat, or register-indexed. The address goes out on a valid/ready handshake, together with the destination register number and, when update is enabled, the register that receives the address. A single-cycle done pulse closes every sequence, including an empty one. Memory access, data formatting and fault handling belong to other blocks.

Top module: `vec_addr_seq`

## Requirements
- R1: After reset `busy`, `rdReq`, `elemValid` and `done` are all low.
- R2: A start with vector length 0 issues no element, and `done` is high in the cycle that follows the clock edge sampling `start`.
- R3: Unit stride (immediate form, scalar base, `cfgStrideOn`=1, `cfgStrideElem`=0): address = reg[base] + i × 2^`cfgWidth`, where width codes 0,1,2,3 mean 1,2,4,8 bytes.
- R4: Element stride (immediate form, scalar base, `cfgStrideOn`=1, `cfgStrideElem`=1): address = reg[base] + i × imm, a 64-bit product and sum wrapping modulo 2^64.
- R5: Immediate-indexed (immediate form, vector base): address = reg[base + i] + imm. The register numbers wrap modulo 2^7.
- R6: Splat (immediate form, scalar base, `cfgStrideOn`=0): every element has address reg[base] + imm, and the source counter stays at 0.
- R7: Register-indexed (`cfgRegForm`=1): address = reg[base + i] + reg[idx + k]. i steps only for a vector base and k only for a vector index. When both are scalar the sequence stops after one element.
- R8: Before each element, the source, index and update counters skip positions whose `cfgSrcMask` bit is clear. The destination counter skips clear bits of `cfgDstMask`. Each counter skips independently, so `elemDstReg` = dst + j may advance differently from the source position.
- R9: The sequence ends, with exactly one `done` pulse, as soon as any active counter reaches the vector length, including while it is skipping.
- R10: With a scalar destination exactly one element is issued, with `elemDstReg` = `cfgDstReg`, at the first enabled source position.
- R11: `elemUpdEn` equals `cfgUpdEn`. `elemUpdReg` = upd + u, where u steps (and skips on the source mask) only when the update operand is a vector; otherwise it stays at upd.
- R12: While `elemValid` is high and `elemReady` low, `elemValid`, `elemAddr`, `elemDstReg` and `elemUpdReg` hold.
- R13: `rdReq` and `rdReg` hold until `rdValid` answers. Register-indexed mode reads base before index, and the returned data forms the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| cfgVl | input | 7 | Vector length, 0 to 64 |
| cfgSrcMask | input | 64 | Source-side predicate mask |
| cfgDstMask | input | 64 | Destination predicate mask |
| cfgRegForm | input | 1 | 1 = register-indexed form, 0 = immediate form |
| cfgBaseVec | input | 1 | Base operand is a vector |
| cfgIdxVec | input | 1 | Index operand is a vector (register form) |
| cfgDstVec | input | 1 | Destination is a vector |
| cfgUpdEn | input | 1 | Write the address back to an update register |
| cfgUpdVec | input | 1 | Update operand is a vector |
| cfgStrideOn | input | 1 | Immediate form with scalar base: 1 = strided, 0 = splat |
| cfgStrideElem | input | 1 | Stride kind: 1 = element stride, 0 = unit stride |
| cfgWidth | input | 2 | Access width code, bytes = 2^code |
| cfgImm | input | 64 | Immediate offset / stride |
| cfgBaseReg | input | 7 | Base register number |
| cfgIdxReg | input | 7 | Index register number |
| cfgDstReg | input | 7 | Destination register number |
| cfgUpdReg | input | 7 | Update register number |
| busy | output | 1 | Sequence in progress |
| rdReq | output | 1 | Register read request |
| rdReg | output | 7 | Register number to read |
| rdValid | input | 1 | Read data valid |
| rdData | input | 64 | Read data |
| elemValid | output | 1 | Element address valid |
| elemReady | input | 1 | Consumer accepts the element |
| elemAddr | output | 64 | Effective address |
| elemDstReg | output | 7 | Destination register for this element |
| elemUpdEn | output | 1 | Update write requested |
| elemUpdReg | output | 7 | Update register for this element |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
On every cycle the assertions check the following:
- the output and read-port holding rules under stall;
- that no counter passes the vector length;
- that every counter active at an issued element sits on an enabled predicate bit;
- that the done pulse lasts a single cycle;
- that a scalar destination or an empty vector ends the sequence.

Only the directed scenarios can show that the address arithmetic of each mode, the independent skipping of the four counters, the exact number of elements, and the register numbers produced match the expected values. These values come from a reference walk over the masks.

// File: rtl/vec_addr_seq_pkg.sv
package vec_addr_seq_pkg;

  typedef enum logic [2:0] {
    MODE_UNIT   = 3'd0,
    MODE_ELEM   = 3'd1,
    MODE_IMMIDX = 3'd2,
    MODE_SPLAT  = 3'd3,
    MODE_REGIDX = 3'd4
  } addrMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic capBase;
    logic capIdx;
    logic selIdx;
  } dpStrobe_t;

  localparam int NUM_CNT = 4;
  localparam int CNT_SRC = 0;
  localparam int CNT_DST = 1;
  localparam int CNT_IDX = 2;
  localparam int CNT_UPD = 3;

  function automatic addrMode_t pickMode(input logic regForm, input logic baseVec,
                                         input logic strideOn, input logic strideElem);
    if (regForm)        return MODE_REGIDX;
    else if (baseVec)   return MODE_IMMIDX;
    else if (!strideOn) return MODE_SPLAT;
    else if (strideElem) return MODE_ELEM;
    else                return MODE_UNIT;
  endfunction

endpackage

// File: rtl/vec_addr_seq_cnt.sv
module vec_addr_seq_cnt #(
  parameter int MAX_VL = 64,
  parameter int CNT_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              active,
  input  logic              skipEn,
  input  logic              stepEn,
  input  logic [MAX_VL-1:0] mask,
  input  logic [CNT_W-1:0]  vl,
  output logic [CNT_W-1:0]  idx,
  output logic              atEnd,
  output logic              needSkip
);
  localparam int IDX_W = $clog2(MAX_VL);

  logic [CNT_W-1:0] idxQ;
  logic             bitSet;

  assign bitSet   = mask[idxQ[IDX_W-1:0]];
  assign atEnd    = active && (idxQ >= vl);
  assign needSkip = active && !atEnd && !bitSet;
  assign idx      = idxQ;

  always_ff @(posedge clk) begin
    if (!rstN)                                     idxQ <= '0;
    else if (clear)                                idxQ <= '0;
    else if ((skipEn && needSkip) || (stepEn && active)) idxQ <= idxQ + 1'b1;
  end

  // R9: a counter never moves past the vector length
  p_within_vl_r9: assert property (@(posedge clk) disable iff (!rstN)
    idxQ <= vl);

  // R8: an element is only issued on an enabled predicate position
  p_emit_on_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && active) |-> (idxQ < vl && bitSet));

endmodule

// File: rtl/vec_addr_seq_ctrl.sv
module vec_addr_seq_ctrl
  import vec_addr_seq_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int CNT_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfgVl,
  input  logic [MAX_VL-1:0] cfgSrcMask,
  input  logic [MAX_VL-1:0] cfgDstMask,
  input  logic              cfgRegForm,
  input  logic              cfgBaseVec,
  input  logic              cfgIdxVec,
  input  logic              cfgDstVec,
  input  logic              cfgUpdEn,
  input  logic              cfgUpdVec,
  input  logic              cfgStrideOn,
  input  logic              cfgStrideElem,
  input  logic              rdValid,
  input  logic              elemReady,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              rdReq,
  output logic              elemValid,
  output logic              done,
  output logic [CNT_W-1:0]  srcIdx,
  output logic [CNT_W-1:0]  dstIdx,
  output logic [CNT_W-1:0]  idxIdx,
  output logic [CNT_W-1:0]  updIdx
);

  typedef enum logic [2:0] {S_IDLE, S_SKIP, S_RDB, S_RDI, S_EMIT, S_DONE} state_t;

  state_t              state, stateNxt;
  logic [CNT_W-1:0]    vlQ;
  logic [MAX_VL-1:0]   srcMaskQ, dstMaskQ;
  logic [NUM_CNT-1:0]  actQ, actD;
  logic                regFormQ, dstVecQ, bothScalarQ;
  logic                clrCnt, skipEn, stepEn, lastElem;
  logic [NUM_CNT-1:0]  cntEnd, cntSkip;
  logic [CNT_W-1:0]    cntIdx [NUM_CNT];
  addrMode_t           modeD;

  assign modeD = pickMode(cfgRegForm, cfgBaseVec, cfgStrideOn, cfgStrideElem);

  always_comb begin
    actD          = '0;
    actD[CNT_SRC] = cfgBaseVec || modeD == MODE_UNIT || modeD == MODE_ELEM;
    actD[CNT_DST] = cfgDstVec;
    actD[CNT_IDX] = cfgRegForm && cfgIdxVec;
    actD[CNT_UPD] = cfgUpdEn && cfgUpdVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlQ         <= '0;
      srcMaskQ    <= '0;
      dstMaskQ    <= '0;
      actQ        <= '0;
      regFormQ    <= 1'b0;
      dstVecQ     <= 1'b0;
      bothScalarQ <= 1'b0;
    end else if (clrCnt) begin
      vlQ         <= cfgVl;
      srcMaskQ    <= cfgSrcMask;
      dstMaskQ    <= cfgDstMask;
      actQ        <= actD;
      regFormQ    <= cfgRegForm;
      dstVecQ     <= cfgDstVec;
      bothScalarQ <= cfgRegForm && !cfgBaseVec && !cfgIdxVec;
    end
  end

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    vec_addr_seq_cnt #(.MAX_VL(MAX_VL), .CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (clrCnt),
      .active   (actQ[c]),
      .skipEn   (skipEn),
      .stepEn   (stepEn),
      .mask     ((c == CNT_DST) ? dstMaskQ : srcMaskQ),
      .vl       (vlQ),
      .idx      (cntIdx[c]),
      .atEnd    (cntEnd[c]),
      .needSkip (cntSkip[c])
    );
  end

  assign srcIdx = cntIdx[CNT_SRC];
  assign dstIdx = cntIdx[CNT_DST];
  assign idxIdx = cntIdx[CNT_IDX];
  assign updIdx = cntIdx[CNT_UPD];

  assign lastElem = !dstVecQ || bothScalarQ;
  assign clrCnt   = (state == S_IDLE) && start;
  assign skipEn   = (state == S_SKIP) && !(|cntEnd) && (|cntSkip);
  assign stepEn   = (state == S_EMIT) && elemReady && !lastElem;

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE: if (start) stateNxt = (cfgVl == '0) ? S_DONE : S_SKIP;
      S_SKIP: begin
        if (|cntEnd)       stateNxt = S_DONE;
        else if (|cntSkip) stateNxt = S_SKIP;
        else               stateNxt = S_RDB;
      end
      S_RDB:  if (rdValid) stateNxt = regFormQ ? S_RDI : S_EMIT;
      S_RDI:  if (rdValid) stateNxt = S_EMIT;
      S_EMIT: if (elemReady) stateNxt = lastElem ? S_DONE : S_SKIP;
      S_DONE: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign strobe.loadCfg = clrCnt;
  assign strobe.capBase = (state == S_RDB) && rdValid;
  assign strobe.capIdx  = (state == S_RDI) && rdValid;
  assign strobe.selIdx  = (state == S_RDI);

  assign busy      = (state != S_IDLE);
  assign rdReq     = (state == S_RDB) || (state == S_RDI);
  assign elemValid = (state == S_EMIT);
  assign done      = (state == S_DONE);

  // R9: end of sequence is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: empty vector finishes at once
  p_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && cfgVl == '0) |=> (done && !elemValid));

  // R13: a read request stays up until answered
  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> rdReq);

  // R10: scalar destination ends after the accepted element
  p_scalar_dst_r10: assert property (@(posedge clk) disable iff (!rstN)
    (elemValid && elemReady && !dstVecQ) |=> done);

  // R12: valid stays while stalled
  p_valid_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (elemValid && !elemReady) |=> elemValid);

endmodule

// File: rtl/vec_addr_seq_dp.sv
module vec_addr_seq_dp
  import vec_addr_seq_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int CNT_W  = $clog2(MAX_VL + 1),
  parameter int ADDR_W = 64,
  parameter int REG_W  = 7,
  parameter int WID_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              cfgRegForm,
  input  logic              cfgBaseVec,
  input  logic              cfgUpdEn,
  input  logic              cfgStrideOn,
  input  logic              cfgStrideElem,
  input  logic [WID_W-1:0]  cfgWidth,
  input  logic [ADDR_W-1:0] cfgImm,
  input  logic [REG_W-1:0]  cfgBaseReg,
  input  logic [REG_W-1:0]  cfgIdxReg,
  input  logic [REG_W-1:0]  cfgDstReg,
  input  logic [REG_W-1:0]  cfgUpdReg,
  input  logic [CNT_W-1:0]  srcIdx,
  input  logic [CNT_W-1:0]  dstIdx,
  input  logic [CNT_W-1:0]  idxIdx,
  input  logic [CNT_W-1:0]  updIdx,
  input  logic [ADDR_W-1:0] rdData,
  input  logic              rdReq,
  input  logic              rdValid,
  input  logic              elemValid,
  input  logic              elemReady,
  output logic [REG_W-1:0]  rdReg,
  output logic [ADDR_W-1:0] elemAddr,
  output logic [REG_W-1:0]  elemDstReg,
  output logic              elemUpdEn,
  output logic [REG_W-1:0]  elemUpdReg
);

  addrMode_t         modeQ;
  logic [ADDR_W-1:0] immQ, baseValQ, idxValQ, offs, srcWide;
  logic [WID_W-1:0]  widthQ;
  logic [REG_W-1:0]  baseRegQ, idxRegQ, dstRegQ, updRegQ;
  logic              baseVecQ, updEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_UNIT;
      immQ     <= '0;
      widthQ   <= '0;
      baseRegQ <= '0;
      idxRegQ  <= '0;
      dstRegQ  <= '0;
      updRegQ  <= '0;
      baseVecQ <= 1'b0;
      updEnQ   <= 1'b0;
    end else if (strobe.loadCfg) begin
      modeQ    <= pickMode(cfgRegForm, cfgBaseVec, cfgStrideOn, cfgStrideElem);
      immQ     <= cfgImm;
      widthQ   <= cfgWidth;
      baseRegQ <= cfgBaseReg;
      idxRegQ  <= cfgIdxReg;
      dstRegQ  <= cfgDstReg;
      updRegQ  <= cfgUpdReg;
      baseVecQ <= cfgBaseVec;
      updEnQ   <= cfgUpdEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseValQ <= '0;
      idxValQ  <= '0;
    end else begin
      if (strobe.capBase) baseValQ <= rdData;
      if (strobe.capIdx)  idxValQ  <= rdData;
    end
  end

  assign rdReg = strobe.selIdx ? (idxRegQ + REG_W'(idxIdx))
                               : (baseRegQ + (baseVecQ ? REG_W'(srcIdx) : '0));

  assign srcWide = ADDR_W'(srcIdx);

  always_comb begin
    unique case (modeQ)
      MODE_UNIT:   offs = srcWide << widthQ;
      MODE_ELEM:   offs = immQ * srcWide;
      MODE_REGIDX: offs = idxValQ;
      default:     offs = immQ;
    endcase
  end

  assign elemAddr   = baseValQ + offs;
  assign elemDstReg = dstRegQ + REG_W'(dstIdx);
  assign elemUpdEn  = updEnQ;
  assign elemUpdReg = updRegQ + REG_W'(updIdx);

  // R12: element fields are frozen under back-pressure
  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (elemValid && !elemReady) |=>
      ($stable(elemAddr) && $stable(elemDstReg) && $stable(elemUpdReg)));

  // R13: register number held while a read is pending
  p_rdreg_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> $stable(rdReg));

endmodule

// File: rtl/vec_addr_seq.sv
module vec_addr_seq
  import vec_addr_seq_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int ADDR_W = 64,
  parameter int REG_W  = 7,
  parameter int WID_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [$clog2(MAX_VL+1)-1:0] cfgVl,
  input  logic [MAX_VL-1:0] cfgSrcMask,
  input  logic [MAX_VL-1:0] cfgDstMask,
  input  logic              cfgRegForm,
  input  logic              cfgBaseVec,
  input  logic              cfgIdxVec,
  input  logic              cfgDstVec,
  input  logic              cfgUpdEn,
  input  logic              cfgUpdVec,
  input  logic              cfgStrideOn,
  input  logic              cfgStrideElem,
  input  logic [WID_W-1:0]  cfgWidth,
  input  logic [ADDR_W-1:0] cfgImm,
  input  logic [REG_W-1:0]  cfgBaseReg,
  input  logic [REG_W-1:0]  cfgIdxReg,
  input  logic [REG_W-1:0]  cfgDstReg,
  input  logic [REG_W-1:0]  cfgUpdReg,
  output logic              busy,
  output logic              rdReq,
  output logic [REG_W-1:0]  rdReg,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdData,
  output logic              elemValid,
  input  logic              elemReady,
  output logic [ADDR_W-1:0] elemAddr,
  output logic [REG_W-1:0]  elemDstReg,
  output logic              elemUpdEn,
  output logic [REG_W-1:0]  elemUpdReg,
  output logic              done
);
  localparam int CNT_W = $clog2(MAX_VL + 1);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] srcIdx, dstIdx, idxIdx, updIdx;

  vec_addr_seq_ctrl #(.MAX_VL(MAX_VL), .CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .start         (start),
    .cfgVl         (cfgVl),
    .cfgSrcMask    (cfgSrcMask),
    .cfgDstMask    (cfgDstMask),
    .cfgRegForm    (cfgRegForm),
    .cfgBaseVec    (cfgBaseVec),
    .cfgIdxVec     (cfgIdxVec),
    .cfgDstVec     (cfgDstVec),
    .cfgUpdEn      (cfgUpdEn),
    .cfgUpdVec     (cfgUpdVec),
    .cfgStrideOn   (cfgStrideOn),
    .cfgStrideElem (cfgStrideElem),
    .rdValid       (rdValid),
    .elemReady     (elemReady),
    .strobe        (strobe),
    .busy          (busy),
    .rdReq         (rdReq),
    .elemValid     (elemValid),
    .done          (done),
    .srcIdx        (srcIdx),
    .dstIdx        (dstIdx),
    .idxIdx        (idxIdx),
    .updIdx        (updIdx)
  );

  vec_addr_seq_dp #(.MAX_VL(MAX_VL), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
                    .REG_W(REG_W), .WID_W(WID_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .cfgRegForm    (cfgRegForm),
    .cfgBaseVec    (cfgBaseVec),
    .cfgUpdEn      (cfgUpdEn),
    .cfgStrideOn   (cfgStrideOn),
    .cfgStrideElem (cfgStrideElem),
    .cfgWidth      (cfgWidth),
    .cfgImm        (cfgImm),
    .cfgBaseReg    (cfgBaseReg),
    .cfgIdxReg     (cfgIdxReg),
    .cfgDstReg     (cfgDstReg),
    .cfgUpdReg     (cfgUpdReg),
    .srcIdx        (srcIdx),
    .dstIdx        (dstIdx),
    .idxIdx        (idxIdx),
    .updIdx        (updIdx),
    .rdData        (rdData),
    .rdReq         (rdReq),
    .rdValid       (rdValid),
    .elemValid     (elemValid),
    .elemReady     (elemReady),
    .rdReg         (rdReg),
    .elemAddr      (elemAddr),
    .elemDstReg    (elemDstReg),
    .elemUpdEn     (elemUpdEn),
    .elemUpdReg    (elemUpdReg)
  );

endmodule

// File: tb/vec_addr_seq_bench.sv
`timescale 1ns/1ps
module vec_addr_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  cVl = '0;
  logic [63:0] cSrcMask = '0, cDstMask = '0;
  logic        cRegForm = 0, cBaseVec = 0, cIdxVec = 0, cDstVec = 0;
  logic        cUpdEn = 0, cUpdVec = 0, cStrideOn = 0, cStrideElem = 0;
  logic [1:0]  cWidth = '0;
  logic [63:0] cImm = '0;
  logic [6:0]  cBaseReg = '0, cIdxReg = '0, cDstReg = '0, cUpdReg = '0;
  logic        busy, rdReq, elemValid, elemUpdEn, done;
  logic [6:0]  rdReg, elemDstReg, elemUpdReg;
  logic        rdValid = 1'b0;
  logic [63:0] rdData = '0;
  logic        elemReady = 1'b0;
  logic [63:0] elemAddr;

  int checks = 0, errors = 0;
  int stallMode = 0;
  int doneCyc = 0;
  int gotN = 0;
  int expN = 0;
  logic [63:0] expAddr [64];
  logic [6:0]  expDst  [64];
  logic [6:0]  expUpd  [64];

  always #2 clk = ~clk;

  vec_addr_seq u_vec_addr_seq (
    .clk(clk), .rstN(rstN), .start(start), .cfgVl(cVl),
    .cfgSrcMask(cSrcMask), .cfgDstMask(cDstMask),
    .cfgRegForm(cRegForm), .cfgBaseVec(cBaseVec), .cfgIdxVec(cIdxVec),
    .cfgDstVec(cDstVec), .cfgUpdEn(cUpdEn), .cfgUpdVec(cUpdVec),
    .cfgStrideOn(cStrideOn), .cfgStrideElem(cStrideElem), .cfgWidth(cWidth),
    .cfgImm(cImm), .cfgBaseReg(cBaseReg), .cfgIdxReg(cIdxReg),
    .cfgDstReg(cDstReg), .cfgUpdReg(cUpdReg), .busy(busy), .rdReq(rdReq),
    .rdReg(rdReg), .rdValid(rdValid), .rdData(rdData), .elemValid(elemValid),
    .elemReady(elemReady), .elemAddr(elemAddr), .elemDstReg(elemDstReg),
    .elemUpdEn(elemUpdEn), .elemUpdReg(elemUpdReg), .done(done)
  );

  function automatic logic [63:0] regVal(input logic [6:0] n);
    return 64'h0000_0100_0000_0000 + {57'd0, n} * 64'h1_0010;
  endfunction

  // register file responder, one cycle of latency, acts away from the active edge
  always @(negedge clk) begin
    if (rdReq && !rdValid) begin
      rdValid <= 1'b1;
      rdData  <= regVal(rdReg);
    end else begin
      rdValid <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearCfg();
    cVl = '0; cSrcMask = '1; cDstMask = '1;
    cRegForm = 0; cBaseVec = 0; cIdxVec = 0; cDstVec = 1;
    cUpdEn = 0; cUpdVec = 0; cStrideOn = 1; cStrideElem = 0;
    cWidth = '0; cImm = '0;
    cBaseReg = 7'd3; cIdxReg = 7'd40; cDstReg = 7'd10; cUpdReg = 7'd90;
    stallMode = 0;
  endtask

  // reference walk built from the requirements
  task automatic buildExp();
    int i = 0, j = 0, k = 0, u = 0;
    bit srcA, dstA, idxA, updA;
    logic [63:0] base, offs;
    expN = 0;
    srcA = cBaseVec || (!cRegForm && cStrideOn);
    dstA = cDstVec;
    idxA = cRegForm && cIdxVec;
    updA = cUpdEn && cUpdVec;
    if (cVl == 0) return;
    while (expN < 64) begin
      if (srcA) while (i < cVl && !cSrcMask[i]) i++;
      if (idxA) while (k < cVl && !cSrcMask[k]) k++;
      if (updA) while (u < cVl && !cSrcMask[u]) u++;
      if (dstA) while (j < cVl && !cDstMask[j]) j++;
      if ((srcA && i >= cVl) || (dstA && j >= cVl) ||
          (idxA && k >= cVl) || (updA && u >= cVl)) break;
      base = regVal(7'(cBaseReg + (cBaseVec ? i : 0)));
      if (cRegForm)                 offs = regVal(7'(cIdxReg + k));
      else if (cBaseVec || !cStrideOn) offs = cImm;
      else if (cStrideElem)         offs = cImm * 64'(i);
      else                          offs = 64'(i * (1 << cWidth));
      expAddr[expN] = base + offs;
      expDst[expN]  = 7'(cDstReg + j);
      expUpd[expN]  = 7'(cUpdReg + u);
      expN++;
      if (!cDstVec) break;
      if (cRegForm && !cBaseVec && !cIdxVec) break;
      if (srcA) i++;
      if (idxA) k++;
      if (updA) u++;
      if (dstA) j++;
    end
  endtask

  task automatic runSeq(input string tag);
    int cyc;
    buildExp();
    gotN = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    doneCyc = -1;
    forever begin
      cyc++;
      elemReady = (stallMode != 0) ? ((cyc % 3) != 0) : 1'b1;
      if (elemValid && elemReady) begin
        if (gotN < expN) begin
          check(elemAddr == expAddr[gotN], tag, $sformatf("addr of element %0d", gotN),
                elemAddr, expAddr[gotN]);
          check(elemDstReg == expDst[gotN], tag, $sformatf("dst reg of element %0d", gotN),
                64'(elemDstReg), 64'(expDst[gotN]));
          check(elemUpdEn == cUpdEn && (!cUpdEn || elemUpdReg == expUpd[gotN]), "R11",
                $sformatf("update of element %0d", gotN),
                64'({elemUpdEn, elemUpdReg}), 64'({cUpdEn, expUpd[gotN]}));
        end
        gotN++;
      end
      if (done) begin
        doneCyc = cyc;
        break;
      end
      if (cyc > 5000) break;
      @(negedge clk);
    end
    elemReady = 1'b0;
    check(doneCyc > 0, "R9", "done pulse seen", 64'(doneCyc), 64'd1);
    check(gotN == expN, tag, "element count", 64'(gotN), 64'(expN));
  endtask

  task automatic tReset();
    check(!busy && !rdReq && !elemValid && !done, "R1", "idle outputs after reset",
          64'({busy, rdReq, elemValid, done}), 64'd0);
  endtask

  task automatic tEmpty();
    clearCfg(); cVl = 7'd0;
    runSeq("R2");
    check(doneCyc == 1, "R2", "done cycle for empty vector", 64'(doneCyc), 64'd1);
    check(gotN == 0, "R2", "no element for empty vector", 64'(gotN), 64'd0);
  endtask

  task automatic tUnit();
    clearCfg(); cVl = 7'd5; cWidth = 2'd3;
    runSeq("R3");
    clearCfg(); cVl = 7'd4; cWidth = 2'd1; cSrcMask = 64'h5;
    runSeq("R3");
  endtask

  task automatic tElem();
    clearCfg(); cVl = 7'd4; cStrideElem = 1; cImm = -64'sd16;
    runSeq("R4");
  endtask

  task automatic tImmIdx();
    clearCfg(); cVl = 7'd6; cBaseVec = 1; cImm = 64'h20; cBaseReg = 7'd125;
    runSeq("R5");
  endtask

  task automatic tSplat();
    clearCfg(); cVl = 7'd5; cStrideOn = 0; cImm = 64'h44;
    cSrcMask = 64'h0; cDstMask = 64'h16;
    runSeq("R6");
  endtask

  task automatic tRegIdx();
    clearCfg(); cRegForm = 1; cBaseVec = 1; cVl = 7'd4;
    runSeq("R7");
    clearCfg(); cRegForm = 1; cIdxVec = 1; cVl = 7'd3; cSrcMask = 64'h6;
    runSeq("R13");
    clearCfg(); cRegForm = 1; cVl = 7'd8;
    runSeq("R7");
    check(gotN == 1, "R7", "both scalar gives one element", 64'(gotN), 64'd1);
  endtask

  task automatic tMasks();
    clearCfg(); cVl = 7'd8; cBaseVec = 1; cImm = 64'h8;
    cSrcMask = 64'hA6; cDstMask = 64'h3C;
    runSeq("R8");
  endtask

  task automatic tEnd();
    clearCfg(); cVl = 7'd64; cWidth = 2'd0;
    runSeq("R9");
    check(gotN == 64, "R9", "full-length element count", 64'(gotN), 64'd64);
    clearCfg(); cVl = 7'd4; cBaseVec = 1; cSrcMask = 64'hF0;
    runSeq("R9");
    check(gotN == 0, "R9", "mask beyond length gives nothing", 64'(gotN), 64'd0);
  endtask

  task automatic tScalarDst();
    clearCfg(); cVl = 7'd8; cBaseVec = 1; cDstVec = 0; cImm = 64'h4;
    cSrcMask = 64'hFC;
    runSeq("R10");
    check(gotN == 1, "R10", "single element for scalar dest", 64'(gotN), 64'd1);
  endtask

  task automatic tUpdate();
    clearCfg(); cVl = 7'd6; cBaseVec = 1; cUpdEn = 1; cUpdVec = 1;
    cSrcMask = 64'h2D; stallMode = 1;
    runSeq("R12");
    clearCfg(); cVl = 7'd3; cUpdEn = 1; cUpdVec = 0; cImm = 64'h10;
    runSeq("R11");
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clearCfg();
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEmpty();
    tUnit();
    tElem();
    tImmIdx();
    tSplat();
    tRegIdx();
    tMasks();
    tEnd();
    tScalarDst();
    tUpdate();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule